// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This controller drives a multi-register move between a register file and word-addressed memory. A caller presents a register-select mask, a base address and four mode bits on a single `start` cycle. The mode bits are step direction, step timing, load versus store, and base update. The sequencer then emits one word transfer request per accepted handshake. Each request names a register index and a byte address, and the memory side paces the walk through a valid/ready pair.

After the final transfer the block raises `done` for one cycle. On that same cycle it can present an updated base value for the caller to write back. When a load includes the highest register, which is the program counter, a strobe tells the fetch logic to redirect.

Transfer back-pressure rules: `xfer_valid` is held until `xfer_ready` is seen high on a rising edge. A transfer completes on exactly the edge where both are high. While valid is high and ready is low, the index, address and direction are frozen. Valid never drops without a completed transfer.

Top module: `blkxfer_seq`

## Requirements
- R1: A `start` pulse is accepted only while `busy` is low. `busy` is high from the cycle after acceptance through the `done` cycle. A `start` seen while busy changes nothing in the ongoing sequence.
- R2: Each selected register is transferred exactly once, in ascending index order, with no unselected index ever presented.
- R3: Consecutive transfers use consecutive word addresses, each 4 bytes above the previous, so the lowest selected register always meets the lowest address.
- R4: With n selected registers, the first address depends on the two mode bits (`req_up`=1 increments, `req_pre`=1 steps before). Up-after starts at base. Up-before starts at base+4. Down-after starts at base-4n+4. Down-before starts at base-4n.
- R5: A transfer completes only on a cycle with `xfer_valid` and `xfer_ready` both high. While valid is high and ready is low, `xfer_reg`, `xfer_addr` and `xfer_load` hold their values into the next cycle.
- R6: The cycle after the last completed transfer, `done` is high. On that same cycle `wb_valid` is high exactly when base update was requested, with `wb_value` = base+4n when incrementing or base-4n when decrementing.
- R7: An empty mask yields `done` on the cycle after `start`, with no transfer request and no `wb_valid`.
- R8: `pc_load` is high only on the completing cycle of a load transfer of index 15. It stays low for stores and for all other cycles.
- R9: `done` lasts exactly one cycle, and `xfer_load` on every transfer equals the `req_load` captured at start.
- R10: During and after reset, until a start is accepted, `busy`, `xfer_valid`, `pc_load`, `wb_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a sequence (ignored while busy) |
| req_mask | input | 16 | Register-select mask, bit i selects register i |
| req_base | input | 32 | Base byte address |
| req_up | input | 1 | 1 increments, 0 decrements |
| req_pre | input | 1 | 1 steps before the access, 0 after |
| req_load | input | 1 | 1 memory-to-register, 0 register-to-memory |
| req_wback | input | 1 | Request base update at the end |
| busy | output | 1 | Sequence in progress |
| xfer_valid | output | 1 | Transfer request valid |
| xfer_ready | input | 1 | Memory accepts the request |
| xfer_reg | output | 4 | Register index of the request |
| xfer_addr | output | 32 | Byte address of the request |
| xfer_load | output | 1 | Direction of the request |
| pc_load | output | 1 | Program counter is being loaded this cycle |
| wb_valid | output | 1 | Base update value is valid |
| wb_value | output | 32 | New base value |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
All four stepping modes are run with the same register-order and address checks. A sequencer that counts downward in decrement modes would put the highest register at the lowest address. One with a wrong first-address offset shifts every address by a word. Memory stalls follow irregular patterns to catch a design that advances its address or index without a handshake. Further scenarios cover an empty mask, a full mask, a store that includes index 15, and a `start` pulse injected mid-sequence. These target a sequencer that hangs or writes back on an empty mask, strobes the program counter on a store, or restarts on a late `start`.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_t;

endpackage

// File: rtl/blkxfer_pick.sv
// Finds the lowest set bit of a register mask and counts the set bits.
module blkxfer_pick #(
  parameter int NREG = 16,
  localparam int IDXW = $clog2(NREG),
  localparam int CNTW = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0] mask,
  output logic [IDXW-1:0] low_idx,
  output logic            any,
  output logic [CNTW-1:0] count
);

  always_comb begin
    low_idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (mask[i]) low_idx = IDXW'(i);
    end
  end

  always_comb begin
    count = '0;
    for (int i = 0; i < NREG; i++) begin
      count = count + CNTW'(mask[i]);
    end
  end

  assign any = |mask;

endmodule

// File: rtl/blkxfer_addr.sv
// Derives the first transfer address and the final base value.
module blkxfer_addr #(
  parameter int AW         = 32,
  parameter int CNTW       = 5,
  parameter int WORD_BYTES = 4
) (
  input  logic [AW-1:0]   base,
  input  logic [CNTW-1:0] count,
  input  logic            up,
  input  logic            pre,
  output logic [AW-1:0]   first_addr,
  output logic [AW-1:0]   final_base
);

  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  logic [AW-1:0] span;
  assign span = AW'(count) * STEP;

  // Decrementing modes still walk upward from the lowest address.
  always_comb begin
    unique case ({up, pre})
      2'b10:   first_addr = base;
      2'b11:   first_addr = base + STEP;
      2'b00:   first_addr = base - span + STEP;
      default: first_addr = base - span;
    endcase
  end

  assign final_base = up ? (base + span) : (base - span);

endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import blkxfer_pkg::*;
#(
  parameter int NREG       = 16,
  parameter int AW         = 32,
  parameter int WORD_BYTES = 4,
  localparam int IDXW      = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NREG-1:0] req_mask,
  input  logic [AW-1:0]   req_base,
  input  logic            req_up,
  input  logic            req_pre,
  input  logic            req_load,
  input  logic            req_wback,
  output logic            busy,
  output logic            xfer_valid,
  input  logic            xfer_ready,
  output logic [IDXW-1:0] xfer_reg,
  output logic [AW-1:0]   xfer_addr,
  output logic            xfer_load,
  output logic            pc_load,
  output logic            wb_valid,
  output logic [AW-1:0]   wb_value,
  output logic            done
);

  localparam int CNTW = $clog2(NREG + 1);
  localparam logic [AW-1:0]   STEP   = AW'(WORD_BYTES);
  localparam logic [IDXW-1:0] PC_IDX = IDXW'(NREG - 1);

  seq_state_t      state_q;
  logic [NREG-1:0] rem_q;
  logic [AW-1:0]   addr_q;
  logic [AW-1:0]   wbv_q;
  logic            load_q;
  logic            wben_q;

  logic [IDXW-1:0] rem_idx, req_low;
  logic            rem_any, req_any;
  logic [CNTW-1:0] rem_cnt, req_cnt;
  logic [AW-1:0]   first_addr, final_base;
  logic            accept, fire, last;

  blkxfer_pick #(.NREG(NREG)) u_rem (
    .mask(rem_q), .low_idx(rem_idx), .any(rem_any), .count(rem_cnt)
  );

  blkxfer_pick #(.NREG(NREG)) u_req (
    .mask(req_mask), .low_idx(req_low), .any(req_any), .count(req_cnt)
  );

  blkxfer_addr #(.AW(AW), .CNTW(CNTW), .WORD_BYTES(WORD_BYTES)) u_addr (
    .base(req_base), .count(req_cnt), .up(req_up), .pre(req_pre),
    .first_addr(first_addr), .final_base(final_base)
  );

  assign accept = start && (state_q == ST_IDLE);
  assign fire   = xfer_valid && xfer_ready;
  assign last   = (rem_cnt == CNTW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      addr_q  <= '0;
      wbv_q   <= '0;
      load_q  <= 1'b0;
      wben_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            rem_q   <= req_mask;
            addr_q  <= first_addr;
            wbv_q   <= final_base;
            load_q  <= req_load;
            wben_q  <= req_wback && req_any;
            state_q <= req_any ? ST_RUN : ST_FIN;
          end
        end
        ST_RUN: begin
          if (xfer_ready) begin
            rem_q[rem_idx] <= 1'b0;
            addr_q         <= addr_q + STEP;
            if (last) state_q <= ST_FIN;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign xfer_valid = (state_q == ST_RUN);
  assign xfer_reg   = rem_idx;
  assign xfer_addr  = addr_q;
  assign xfer_load  = load_q;
  assign pc_load    = fire && load_q && (rem_idx == PC_IDX);
  assign done       = (state_q == ST_FIN);
  assign wb_valid   = done && wben_q;
  assign wb_value   = wbv_q;

  AST_FIRST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_any |=> xfer_valid && (xfer_reg == $past(req_low))); // R2

  AST_RUN_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> rem_any); // R2

  AST_REG_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !last |=> xfer_valid && (xfer_reg > $past(xfer_reg))); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !last |=> xfer_addr == $past(xfer_addr) + STEP); // R3

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_addr)
      && $stable(xfer_reg) && $stable(xfer_load)); // R5

  AST_LAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fire && last |=> done && !xfer_valid); // R6

  AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !req_any |=> done && !wb_valid && !xfer_valid); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

endmodule

// File: tb/sim_blkxfer_seq.sv
`timescale 1ns/1ps
module sim_blkxfer_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] req_mask = '0;
  logic [31:0] req_base = '0;
  logic        req_up = 1'b0, req_pre = 1'b0, req_load = 1'b0, req_wback = 1'b0;
  logic        busy, xfer_valid, xfer_load, pc_load, wb_valid, done;
  logic        xfer_ready = 1'b0;
  logic [3:0]  xfer_reg;
  logic [31:0] xfer_addr, wb_value;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  blkxfer_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .req_mask(req_mask),
    .req_base(req_base), .req_up(req_up), .req_pre(req_pre),
    .req_load(req_load), .req_wback(req_wback), .busy(busy),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_reg(xfer_reg),
    .xfer_addr(xfer_addr), .xfer_load(xfer_load), .pc_load(pc_load),
    .wb_valid(wb_valid), .wb_value(wb_value), .done(done)
  );

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R10", "outputs in reset",
        {27'd0, busy, xfer_valid, pc_load, wb_valid, done}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R10", "outputs after reset",
        {27'd0, busy, xfer_valid, pc_load, wb_valid, done}, 32'd0);
  endtask

  // Shared scenario driver; computes expectations from the requirements.
  task automatic run_xfer(input string tag, input logic [15:0] m,
                          input logic [31:0] b, input bit up, input bit pre,
                          input bit ld, input bit wb, input logic [7:0] rpat,
                          input bit poke);
    int n, k;
    logic [3:0]  ei [16];
    logic [31:0] span, a0, wexp, sa;
    logic [3:0]  sr;
    bit fin, stall_prev;
    n = 0;
    for (int i = 0; i < 16; i++) if (m[i]) begin ei[n] = 4'(i); n++; end
    span = 32'(n) * 32'd4;
    a0   = up ? (pre ? b + 32'd4 : b) : (pre ? b - span : b - span + 32'd4);
    wexp = up ? b + span : b - span;
    @(negedge clk);
    start = 1'b1; req_mask = m; req_base = b; req_up = up; req_pre = pre;
    req_load = ld; req_wback = wb; xfer_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    k = 0; fin = 0; stall_prev = 0; sa = '0; sr = '0;
    for (int c = 0; c < 120 && !fin; c++) begin
      if (c > 0) @(negedge clk);
      xfer_ready = rpat[c % 8];
      if (poke && c == 1) begin
        start = 1'b1; req_mask = 16'hFFFF; req_base = 32'h0; req_up = ~up;
        req_load = ~ld; req_wback = ~wb;
      end else begin
        start = 1'b0;
      end
      #1;
      chk("R1", {tag, " busy during sequence"}, 32'(busy), 32'd1);
      if (stall_prev)
        chk("R5", {tag, " hold under stall"},
            {xfer_valid, 23'd0, sr, 4'd0}, {1'b1, 23'd0, xfer_reg, 4'd0} & 32'h0 | {1'b1, 23'd0, sr, 4'd0});
      if (stall_prev) chk("R5", {tag, " address held"}, xfer_addr, sa);
      if (xfer_valid && xfer_ready) begin
        if (k < n) begin
          chk("R2", {tag, " register order"}, 32'(xfer_reg), 32'(ei[k]));
          chk(k == 0 ? "R4" : "R3", {tag, " address"}, xfer_addr, a0 + 32'(k) * 32'd4);
          chk("R9", {tag, " direction"}, 32'(xfer_load), 32'(ld));
          chk("R8", {tag, " pc strobe"}, 32'(pc_load), 32'(ld && ei[k] == 4'd15));
        end
        k++;
      end else begin
        chk("R8", {tag, " pc strobe idle"}, 32'(pc_load), 32'd0);
      end
      stall_prev = xfer_valid && !xfer_ready;
      sa = xfer_addr; sr = xfer_reg;
      if (done) begin
        fin = 1;
        chk(n == 0 ? "R7" : "R6", {tag, " transfer count"}, 32'(k), 32'(n));
        chk(n == 0 ? "R7" : "R6", {tag, " wb_valid"}, 32'(wb_valid), 32'(wb && n > 0));
        if (wb && n > 0) chk("R6", {tag, " wb_value"}, wb_value, wexp);
        chk("R7", {tag, " no request at done"}, 32'(xfer_valid), 32'd0);
        if (n == 0) chk("R7", {tag, " done next cycle"}, 32'(c), 32'd0);
      end
    end
    start = 1'b0;
    chk("R1", {tag, " sequence finished"}, 32'(fin), 32'd1);
    @(negedge clk);
    xfer_ready = 1'b0;
    #1;
    chk("R9", {tag, " done single cycle"}, 32'(done), 32'd0);
    chk("R1", {tag, " idle after done"}, 32'(busy), 32'd0);
  endtask

  task automatic t_up_after();
    run_xfer("up-after", 16'h00C3, 32'h0000_1000, 1, 0, 1, 1, 8'hFF, 0);
  endtask

  task automatic t_down_before_store_pc();
    run_xfer("down-before store", 16'h8421, 32'h0000_2000, 0, 1, 0, 1, 8'b1010_0110, 0);
  endtask

  task automatic t_down_after();
    run_xfer("down-after", 16'h0F00, 32'h0000_3000, 0, 0, 1, 0, 8'b1100_1101, 0);
  endtask

  task automatic t_up_before_pc_load();
    run_xfer("up-before pc", 16'h8003, 32'h0000_4000, 1, 1, 1, 1, 8'b0111_1011, 0);
  endtask

  task automatic t_empty();
    run_xfer("empty", 16'h0000, 32'h0000_6000, 1, 0, 1, 1, 8'hFF, 0);
  endtask

  task automatic t_full();
    run_xfer("full", 16'hFFFF, 32'h0000_0100, 0, 1, 1, 1, 8'hFF, 0);
  endtask

  task automatic t_start_while_busy();
    run_xfer("late start", 16'h0070, 32'h0000_5000, 1, 0, 0, 1, 8'b0000_1001, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_up_after();
    t_down_before_store_pc();
    t_down_after();
    t_up_before_pc_load();
    t_empty();
    t_full();
    t_start_while_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule